// File: doc/BRIEF.md
# Dual Parallel Cell Link to a Switch Fabric

This block carries fixed-length cells between a port controller and a switch fabric over a byte-wide parallel link. Each link has a valid strobe, a cell-start strobe, eight data lines and one parity line per direction. There are two identical copies of the link, so that a pair of redundant fabrics can be attached.

The transmit side of each link reads a cell one byte per clock from a buffer outside the block. It does this through an index and data port and puts the bytes on the bus with a parity bit. The parity sense is chosen per link: odd or even. Each transmitter has its own enable.

The receive side checks every byte against odd parity and checks the framing of each cell. It writes the bytes, with their index, to a buffer outside the block. A full cell is confirmed with a commit pulse. A broken cell is rejected with a drop pulse. The receiver also keeps the backpressure bits carried in the header of the last good cell.

A loopback mode feeds each link's own transmit bus into its receiver, so that a single controller can run without a fabric.

Top module: `cell_link_top`

## Requirements
- R1: When a link's transmitter is idle, enabled and `txCellReady` is high, it starts a cell in the next cycle. It reads bytes at indexes 0 to CELL_BYTES-1 on consecutive cycles through `txByteIdx`/`txByteIn`. It puts each byte on `linkTxData` one cycle after the read, with `linkTxValid` high and `linkTxSoc` high only with byte 0. `txCellDone` is high during the read of the last byte. At least one idle cycle follows every cell.
- R2: With `txParOdd` high, each transmitted byte plus `linkTxPar` holds an odd number of ones. With `txParOdd` low, it holds an even number.
- R3: An idle transmitter whose `txEnable` is low starts no cell. Its bus shows valid, cell-start and data all zero. Dropping the enable in the middle of a cell lets that cell finish in full.
- R4: A received byte whose eight data bits plus the parity bit hold an even number of ones raises `rxParErr` in the cycle that byte is written. The cell is still committed if its framing is good.
- R5: Every byte the receiver accepts is written with `rxWrEn`, `rxWrIdx` and `rxWrByte`. This happens two clock edges after the byte is on the receive bus. The cell-start byte has index 0, and each later byte takes the next index. `rxCellCommit` is raised together with the write of index CELL_BYTES-1 of a cell whose bytes arrived on consecutive cycles. Cells may follow each other with no gap.
- R6: Three events are protocol violations: a cell-start before a cell is complete, a cycle without valid inside a cell, and a valid byte without cell-start outside a cell. Any of them sets `rxProtoErr`, which stays set until reset. A partial cell is never committed and gets one `rxCellDrop` pulse. A cell-start in the middle of a cell also begins a new cell at index 0. A stray byte outside a cell is not written.
- R7: `rxBackpressure` holds the low BP_BITS bits of byte 0 of the last committed cell. It changes only with a commit, so dropped cells leave it unchanged.
- R8: With `loopEn` high, each link's receiver takes that link's own transmit bus, and the receive pins are ignored. The transmit pins keep carrying the cells.
- R9: The links are independent. Enabling, sending or receiving on one link has no effect on the other link's outputs.
- R10: After reset, the transmit bus is idle, no write, commit or drop is signalled, `rxProtoErr` is low and `rxBackpressure` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loopEn | input | 1 | Route each transmit bus to its own receiver |
| txEnable | input | NUM_LINKS | Per-link transmit enable |
| txParOdd | input | NUM_LINKS | Per-link transmit parity sense, 1 = odd |
| txCellReady | input | NUM_LINKS | A cell is waiting in the source buffer |
| txCellDone | output | NUM_LINKS | Last byte of the current cell is being read |
| txByteIdx | output | NUM_LINKS x IDXW | Byte index read from the source buffer |
| txByteIn | input | NUM_LINKS x 8 | Source byte at `txByteIdx` |
| linkTxValid | output | NUM_LINKS | Transmit bus byte valid |
| linkTxSoc | output | NUM_LINKS | Transmit bus cell start |
| linkTxData | output | NUM_LINKS x 8 | Transmit bus data |
| linkTxPar | output | NUM_LINKS | Transmit bus parity |
| linkRxValid | input | NUM_LINKS | Receive bus byte valid |
| linkRxSoc | input | NUM_LINKS | Receive bus cell start |
| linkRxData | input | NUM_LINKS x 8 | Receive bus data |
| linkRxPar | input | NUM_LINKS | Receive bus parity |
| rxWrEn | output | NUM_LINKS | Write of a received byte |
| rxWrIdx | output | NUM_LINKS x IDXW | Index of the written byte |
| rxWrByte | output | NUM_LINKS x 8 | Written byte |
| rxParErr | output | NUM_LINKS | Written byte failed the odd parity check |
| rxCellCommit | output | NUM_LINKS | Received cell is complete |
| rxCellDrop | output | NUM_LINKS | Partial cell rejected |
| rxProtoErr | output | NUM_LINKS | Sticky protocol violation flag |
| rxBackpressure | output | NUM_LINKS x BP_BITS | Backpressure bits from the last committed header |

## Verification
The assertions check rules that must hold on every cycle. A transmit cell runs on consecutive cycles and is followed by a gap, and a disabled idle transmitter stays idle. A commit comes only with the write of the last index and never with a drop. The violation flag is sticky, a parity error comes only with a write, and the backpressure bits move only on a commit. Other behaviour can only be shown by the bench's scenarios, which compare results against values computed from a byte pattern. Those scenarios cover the exact byte stream and its parity under both senses, and the loopback path and the independence of the two links. They also cover the finishing of a cell after a late disable, and the recovery after an early cell-start, a gap and a stray byte.

// File: rtl/cell_link_pkg.sv
package cell_link_pkg;

  // Strobes from a link controller to its datapath, one cycle's worth.
  typedef struct packed {
    logic txLoad;    // transmit a byte read this cycle
    logic txFirst;   // that byte is byte 0 of a cell
    logic rxWr;      // write the registered receive byte
    logic rxFirst;   // the written byte is a header byte 0
    logic rxCommit;  // the written byte completes a cell
    logic rxDrop;    // the cell in progress is abandoned
    logic rxViol;    // a framing violation was seen
  } link_strobe_t;

endpackage

// File: rtl/cell_link_ctrl.sv
module cell_link_ctrl
  import cell_link_pkg::*;
#(
  parameter int CELL_BYTES = 64,
  localparam int IDXW = $clog2(CELL_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txEnable,
  input  logic            txCellReady,
  output logic            txCellDone,
  output logic [IDXW-1:0] txByteIdx,
  input  logic            rxInValid,
  input  logic            rxInSoc,
  output logic [IDXW-1:0] rxIdx,
  output link_strobe_t    stb
);

  localparam logic [IDXW-1:0] LAST = IDXW'(CELL_BYTES - 1);

  logic            txBusy;
  logic [IDXW-1:0] txCnt;
  logic            rxBusy, rxBusyNext;
  logic [IDXW-1:0] rxCnt, rxCntNext;

  // Transmit sequencer: an enable is only sampled between cells.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (!txBusy) begin
      if (txEnable && txCellReady) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
      end
    end else if (txCnt == LAST) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  assign txByteIdx  = txCnt;
  assign txCellDone = txBusy && (txCnt == LAST);

  // Receive framing decisions on the registered receive byte.
  always_comb begin
    stb          = '0;
    stb.txLoad   = txBusy;
    stb.txFirst  = txBusy && (txCnt == '0);
    rxIdx        = rxCnt;
    rxBusyNext   = rxBusy;
    rxCntNext    = rxCnt;
    if (rxInValid) begin
      if (rxInSoc) begin
        stb.rxWr    = 1'b1;
        stb.rxFirst = 1'b1;
        rxIdx       = '0;
        if (rxBusy) begin
          stb.rxViol = 1'b1;
          stb.rxDrop = 1'b1;
        end
        rxBusyNext = 1'b1;
        rxCntNext  = IDXW'(1);
      end else if (rxBusy) begin
        stb.rxWr = 1'b1;
        if (rxCnt == LAST) begin
          stb.rxCommit = 1'b1;
          rxBusyNext   = 1'b0;
          rxCntNext    = '0;
        end else begin
          rxCntNext = rxCnt + 1'b1;
        end
      end else begin
        stb.rxViol = 1'b1;
      end
    end else if (rxBusy) begin
      stb.rxViol = 1'b1;
      stb.rxDrop = 1'b1;
      rxBusyNext = 1'b0;
      rxCntNext  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else begin
      rxBusy <= rxBusyNext;
      rxCnt  <= rxCntNext;
    end
  end

  AST_TX_CELL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txCnt != LAST) |=> (txBusy && txCnt == $past(txCnt) + 1'b1)); // R1
  AST_TX_GAP_AFTER_CELL: assert property (@(posedge clk) disable iff (!rstN)
    txCellDone |=> !txBusy); // R1
  AST_TX_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && !txEnable) |=> !txBusy); // R3

endmodule

// File: rtl/cell_link_dp.sv
module cell_link_dp
  import cell_link_pkg::*;
#(
  parameter int CELL_BYTES = 64,
  parameter int BP_BITS    = 2,
  localparam int IDXW = $clog2(CELL_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loopEn,
  input  logic               txParOdd,
  input  logic [7:0]         txByteIn,
  input  link_strobe_t       stb,
  input  logic [IDXW-1:0]    rxIdx,
  output logic               linkTxValid,
  output logic               linkTxSoc,
  output logic [7:0]         linkTxData,
  output logic               linkTxPar,
  input  logic               linkRxValid,
  input  logic               linkRxSoc,
  input  logic [7:0]         linkRxData,
  input  logic               linkRxPar,
  output logic               rxInValid,
  output logic               rxInSoc,
  output logic               rxWrEn,
  output logic [IDXW-1:0]    rxWrIdx,
  output logic [7:0]         rxWrByte,
  output logic               rxParErr,
  output logic               rxCellCommit,
  output logic               rxCellDrop,
  output logic               rxProtoErr,
  output logic [BP_BITS-1:0] rxBackpressure
);

  localparam logic [IDXW-1:0] LAST = IDXW'(CELL_BYTES - 1);

  logic [7:0]         rxInData;
  logic               rxInPar;
  logic               srcValid, srcSoc, srcPar;
  logic [7:0]         srcData;
  logic [BP_BITS-1:0] bpPend;

  // Transmit bus register with parity of the selected sense.
  always_ff @(posedge clk) begin
    if (!rstN || !stb.txLoad) begin
      linkTxValid <= 1'b0;
      linkTxSoc   <= 1'b0;
      linkTxData  <= '0;
      linkTxPar   <= 1'b0;
    end else begin
      linkTxValid <= 1'b1;
      linkTxSoc   <= stb.txFirst;
      linkTxData  <= txByteIn;
      linkTxPar   <= txParOdd ? ~(^txByteIn) : (^txByteIn);
    end
  end

  // Receive source select: own transmit bus in loopback, pins otherwise.
  always_comb begin
    if (loopEn) begin
      srcValid = linkTxValid;
      srcSoc   = linkTxSoc;
      srcData  = linkTxData;
      srcPar   = linkTxPar;
    end else begin
      srcValid = linkRxValid;
      srcSoc   = linkRxSoc;
      srcData  = linkRxData;
      srcPar   = linkRxPar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxInValid <= 1'b0;
      rxInSoc   <= 1'b0;
      rxInData  <= '0;
      rxInPar   <= 1'b0;
    end else begin
      rxInValid <= srcValid;
      rxInSoc   <= srcSoc;
      rxInData  <= srcData;
      rxInPar   <= srcPar;
    end
  end

  // Receive write port, status and header capture.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWrEn         <= 1'b0;
      rxWrIdx        <= '0;
      rxWrByte       <= '0;
      rxParErr       <= 1'b0;
      rxCellCommit   <= 1'b0;
      rxCellDrop     <= 1'b0;
      rxProtoErr     <= 1'b0;
      bpPend         <= '0;
      rxBackpressure <= '0;
    end else begin
      rxWrEn       <= stb.rxWr;
      rxWrIdx      <= rxIdx;
      rxWrByte     <= rxInData;
      rxParErr     <= stb.rxWr && !(^{rxInData, rxInPar});
      rxCellCommit <= stb.rxCommit;
      rxCellDrop   <= stb.rxDrop;
      rxProtoErr   <= rxProtoErr || stb.rxViol;
      if (stb.rxFirst) bpPend <= rxInData[BP_BITS-1:0];
      if (stb.rxCommit) rxBackpressure <= bpPend;
    end
  end

  AST_RX_COMMIT_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rxCellCommit |-> (rxWrEn && rxWrIdx == LAST)); // R5
  AST_RX_DROP_NOT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    rxCellDrop |-> !rxCellCommit); // R6
  AST_RX_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rxProtoErr |=> rxProtoErr); // R6
  AST_RX_PARERR_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxParErr |-> rxWrEn); // R4
  AST_BP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !rxCellCommit |-> $stable(rxBackpressure)); // R7

endmodule

// File: rtl/cell_link_top.sv
module cell_link_top
  import cell_link_pkg::*;
#(
  parameter int NUM_LINKS  = 2,
  parameter int CELL_BYTES = 64,
  parameter int BP_BITS    = 2,
  localparam int IDXW = $clog2(CELL_BYTES)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                loopEn,
  input  logic [NUM_LINKS-1:0]                txEnable,
  input  logic [NUM_LINKS-1:0]                txParOdd,
  input  logic [NUM_LINKS-1:0]                txCellReady,
  output logic [NUM_LINKS-1:0]                txCellDone,
  output logic [NUM_LINKS-1:0][IDXW-1:0]      txByteIdx,
  input  logic [NUM_LINKS-1:0][7:0]           txByteIn,
  output logic [NUM_LINKS-1:0]                linkTxValid,
  output logic [NUM_LINKS-1:0]                linkTxSoc,
  output logic [NUM_LINKS-1:0][7:0]           linkTxData,
  output logic [NUM_LINKS-1:0]                linkTxPar,
  input  logic [NUM_LINKS-1:0]                linkRxValid,
  input  logic [NUM_LINKS-1:0]                linkRxSoc,
  input  logic [NUM_LINKS-1:0][7:0]           linkRxData,
  input  logic [NUM_LINKS-1:0]                linkRxPar,
  output logic [NUM_LINKS-1:0]                rxWrEn,
  output logic [NUM_LINKS-1:0][IDXW-1:0]      rxWrIdx,
  output logic [NUM_LINKS-1:0][7:0]           rxWrByte,
  output logic [NUM_LINKS-1:0]                rxParErr,
  output logic [NUM_LINKS-1:0]                rxCellCommit,
  output logic [NUM_LINKS-1:0]                rxCellDrop,
  output logic [NUM_LINKS-1:0]                rxProtoErr,
  output logic [NUM_LINKS-1:0][BP_BITS-1:0]   rxBackpressure
);

  for (genvar g = 0; g < NUM_LINKS; g++) begin : gLink
    link_strobe_t    stb;
    logic [IDXW-1:0] rxIdx;
    logic            rxInValid, rxInSoc;

    cell_link_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .txEnable   (txEnable[g]),
      .txCellReady(txCellReady[g]),
      .txCellDone (txCellDone[g]),
      .txByteIdx  (txByteIdx[g]),
      .rxInValid  (rxInValid),
      .rxInSoc    (rxInSoc),
      .rxIdx      (rxIdx),
      .stb        (stb)
    );

    cell_link_dp #(.CELL_BYTES(CELL_BYTES), .BP_BITS(BP_BITS)) u_dp (
      .clk           (clk),
      .rstN          (rstN),
      .loopEn        (loopEn),
      .txParOdd      (txParOdd[g]),
      .txByteIn      (txByteIn[g]),
      .stb           (stb),
      .rxIdx         (rxIdx),
      .linkTxValid   (linkTxValid[g]),
      .linkTxSoc     (linkTxSoc[g]),
      .linkTxData    (linkTxData[g]),
      .linkTxPar     (linkTxPar[g]),
      .linkRxValid   (linkRxValid[g]),
      .linkRxSoc     (linkRxSoc[g]),
      .linkRxData    (linkRxData[g]),
      .linkRxPar     (linkRxPar[g]),
      .rxInValid     (rxInValid),
      .rxInSoc       (rxInSoc),
      .rxWrEn        (rxWrEn[g]),
      .rxWrIdx       (rxWrIdx[g]),
      .rxWrByte      (rxWrByte[g]),
      .rxParErr      (rxParErr[g]),
      .rxCellCommit  (rxCellCommit[g]),
      .rxCellDrop    (rxCellDrop[g]),
      .rxProtoErr    (rxProtoErr[g]),
      .rxBackpressure(rxBackpressure[g])
    );
  end

endmodule

// File: tb/cell_link_top_tb.sv
module cell_link_top_tb;

  localparam int NL   = 2;
  localparam int CB   = 64;
  localparam int BPB  = 2;
  localparam int IDXW = $clog2(CB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loopEn;
  logic [NL-1:0] txEnable, txParOdd, txCellReady, txCellDone;
  logic [NL-1:0][IDXW-1:0] txByteIdx, rxWrIdx;
  logic [NL-1:0][7:0] txByteIn, linkTxData, linkRxData, rxWrByte;
  logic [NL-1:0] linkTxValid, linkTxSoc, linkTxPar;
  logic [NL-1:0] linkRxValid, linkRxSoc, linkRxPar;
  logic [NL-1:0] rxWrEn, rxParErr, rxCellCommit, rxCellDrop, rxProtoErr;
  logic [NL-1:0][BPB-1:0] rxBackpressure;

  always #4 clk = ~clk;

  cell_link_top #(.NUM_LINKS(NL), .CELL_BYTES(CB), .BP_BITS(BPB)) u_dut (.*);

  int checks = 0, fails = 0;
  bit chkData = 1'b1;
  int srcCell[NL], commits[NL], drops[NL], writes[NL], parErrs[NL];
  int dataErr[NL], txParBad[NL], txValidCycles[NL];
  bit pendInc[NL];

  function automatic logic [7:0] pat(int l, int c, int j);
    return 8'(l * 97 + c * 13 + j * 7 + 5);
  endfunction

  always_comb
    for (int l = 0; l < NL; l++) txByteIn[l] = pat(l, srcCell[l], int'(txByteIdx[l]));

  // Source-buffer model and port monitors, all at the falling edge.
  always @(negedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (pendInc[l] && !txCellDone[l]) begin srcCell[l]++; pendInc[l] = 1'b0; end
      if (txCellDone[l]) pendInc[l] = 1'b1;
      if (linkTxValid[l]) begin
        txValidCycles[l]++;
        if (linkTxPar[l] != (txParOdd[l] ? ~(^linkTxData[l]) : (^linkTxData[l]))) txParBad[l]++;
      end
      if (rxWrEn[l]) begin
        writes[l]++;
        if (chkData && rxWrByte[l] != pat(l, commits[l], int'(rxWrIdx[l]))) dataErr[l]++;
        if (rxParErr[l]) parErrs[l]++;
      end
      if (rxCellCommit[l]) commits[l]++;
      if (rxCellDrop[l]) drops[l]++;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pinByte(int l, bit v, bit s, logic [7:0] d, bit badPar);
    @(negedge clk);
    linkRxValid[l] = v;
    linkRxSoc[l]   = s;
    linkRxData[l]  = d;
    linkRxPar[l]   = (~(^d)) ^ badPar;
  endtask

  task automatic pinCell(int l, int n, logic [7:0] base, int badAt);
    for (int j = 0; j < n; j++) pinByte(l, 1'b1, j == 0, 8'(base + j), j == badAt);
  endtask

  task automatic pinIdle(int l);
    pinByte(l, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v0, v1, w1, cm0, cm1, dr0, wr0, pe1;
    loopEn = 1'b1;
    txEnable = '0;
    txParOdd = 2'b01;
    txCellReady = '1;
    // junk on the receive pins: must be ignored in loopback (R8)
    linkRxValid = '1; linkRxSoc = '0; linkRxData = {8'hA5, 8'h5A}; linkRxPar = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    settle(1);
    // R10 reset state
    checkEq("R10 tx valid after reset", int'(linkTxValid), 0);
    checkEq("R10 rx write after reset", int'(rxWrEn), 0);
    checkEq("R10 proto flag after reset", int'(rxProtoErr), 0);
    checkEq("R10 backpressure after reset", int'(rxBackpressure), 0);

    // R3 disabled idle transmitters stay silent
    settle(10);
    checkEq("R3 no tx while disabled l0", txValidCycles[0], 0);
    checkEq("R3 no tx while disabled l1", txValidCycles[1], 0);
    checkEq("R3 idle data zero", int'(linkTxData), 0);
    checkEq("R3 idle soc zero", int'(linkTxSoc), 0);

    // R1 R2 R5 R8 loopback streaming, odd sense on link 0, even on link 1
    txEnable = '1;
    while (commits[0] < 3 || commits[1] < 3) @(negedge clk);
    txEnable = '0;
    settle(150);
    for (int l = 0; l < NL; l++) begin
      checkEq($sformatf("R1 R5 R8 byte stream link%0d", l), dataErr[l], 0);
      checkEq($sformatf("R5 writes per commit link%0d", l), writes[l], commits[l] * CB);
      checkEq($sformatf("R1 R3 whole cells sent link%0d", l), txValidCycles[l], commits[l] * CB);
      checkEq($sformatf("R2 tx parity sense link%0d", l), txParBad[l], 0);
      checkEq($sformatf("R8 pins ignored link%0d", l), int'(rxProtoErr[l]), 0);
      checkEq($sformatf("R7 backpressure link%0d", l), int'(rxBackpressure[l]),
              int'(pat(l, commits[l] - 1, 0) & 8'h03));
      checkEq($sformatf("R6 no drops link%0d", l), drops[l], 0);
    end
    checkEq("R4 odd sense no parity errors", parErrs[0], 0);
    checkEq("R2 R4 even sense flagged per byte", parErrs[1], writes[1]);

    // R3 R9 late disable on link 0 completes the cell, link 1 untouched
    v0 = txValidCycles[0]; v1 = txValidCycles[1]; w1 = writes[1];
    txEnable[0] = 1'b1;
    while (!linkTxValid[0]) @(negedge clk);
    repeat (5) @(negedge clk);
    txEnable[0] = 1'b0;
    settle(150);
    checkEq("R3 disable mid-cell finishes cell", txValidCycles[0] - v0, CB);
    checkEq("R9 other link tx idle", txValidCycles[1] - v1, 0);
    checkEq("R9 other link rx idle", writes[1] - w1, 0);
    checkEq("R1 R8 late cell bytes", dataErr[0], 0);

    // pin-driven receive tests
    @(negedge clk);
    linkRxValid = '0;
    loopEn = 1'b0;
    chkData = 1'b0;
    settle(3);

    // R6 R7 early cell-start on link 0
    cm0 = commits[0]; dr0 = drops[0]; wr0 = writes[0];
    pinCell(0, 10, 8'h40, -1);
    pinCell(0, CB, 8'h22, -1);
    pinIdle(0);
    settle(4);
    checkEq("R6 early start drop", drops[0] - dr0, 1);
    checkEq("R6 early start then full commit", commits[0] - cm0, 1);
    checkEq("R6 proto flag set", int'(rxProtoErr[0]), 1);
    checkEq("R5 partial and full writes", writes[0] - wr0, 10 + CB);
    checkEq("R7 header of committed cell", int'(rxBackpressure[0]), 2);

    // R6 R7 gap inside a cell
    cm0 = commits[0]; dr0 = drops[0];
    pinCell(0, 20, 8'h13, -1);
    pinIdle(0);
    settle(4);
    checkEq("R6 gap drop", drops[0] - dr0, 1);
    checkEq("R6 gap no commit", commits[0] - cm0, 0);
    checkEq("R7 drop keeps backpressure", int'(rxBackpressure[0]), 2);
    checkEq("R6 flag sticky", int'(rxProtoErr[0]), 1);

    // R6 R9 stray byte on link 1
    checkEq("R9 link1 flag clear before", int'(rxProtoErr[1]), 0);
    w1 = writes[1];
    pinByte(1, 1'b1, 1'b0, 8'h77, 1'b0);
    pinIdle(1);
    settle(4);
    checkEq("R6 stray byte flagged", int'(rxProtoErr[1]), 1);
    checkEq("R6 stray byte not written", writes[1] - w1, 0);

    // R4 R5 bad parity byte, then a back-to-back cell
    cm1 = commits[1]; pe1 = parErrs[1];
    pinCell(1, CB, 8'h01, 5);
    pinCell(1, CB, 8'h07, -1);
    pinIdle(1);
    settle(4);
    checkEq("R4 one parity error", parErrs[1] - pe1, 1);
    checkEq("R4 R5 both cells committed", commits[1] - cm1, 2);
    checkEq("R7 back-to-back header", int'(rxBackpressure[1]), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule